// File: doc/BRIEF.md
# Write-Masked GPIO Register Controller

This block drives 32 general-purpose pins from a small memory-mapped register bus with a 32-bit word. Output levels and pin directions are each held in two 16-bit halves. One half serves pins 0 to 15 and the other serves pins 16 to 31. Every write word carries its own per-bit enable mask in its upper 16 bits. Software can therefore set or clear any subset of pins in one bus write, with no read-modify-write sequence. Two agents that touch different pins of the same register need no lock.

Pin levels come back through a two-flop synchroniser as one 32-bit word. A constant identification word lets software tell which register layout is present. The pad side presents an output value and an output enable for each pin, meant for an external tri-state buffer, and takes one input level for each pin.

The bus is single-cycle. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `bus_addr` while `rd_en` is high, and is zero while `rd_en` is low.

Top module: `gpio_mask_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every output-value bit and every direction bit is 0. `pad_out` and `pad_oe` are all zero, so all pins start as inputs.
- R2: On a write to a control register, stored bit n (n = 0..15) takes `wr_data[n]` only when `wr_data[n+16]` is 1. Otherwise it keeps its previous value.
- R3: Output values are set through two registers. Byte offset 0x000 holds pins 0..15 in bits 0..15. Byte offset 0x004 holds pins 16..31 in bits 0..15. `pad_out[k]` equals the stored bit for pin k.
- R4: Directions are set through two registers. Offset 0x008 holds pins 0..15 and offset 0x00C holds pins 16..31. `pad_oe[k]` equals the stored direction bit, where 1 means output and 0 means input.
- R5: A read of any of the four control registers returns the 16 stored bits in bits 15..0 and zeros in bits 31..16.
- R6: A read at offset 0x070 returns the pin levels, with bit k showing `pad_in[k]` as it stood two rising clock edges earlier (two-flop synchroniser, reset to 0).
- R7: A read at offset 0x078 returns the constant 0x0101157C.
- R8: A read at any other offset returns 0. A write to any offset other than the four control registers, including 0x070 and 0x078, changes no stored bit.
- R9: Two writes to the same register with disjoint masks each change only their own bits. Each leaves the other's bits as they were.
- R10: While `rd_en` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write word: enable mask in [31:16], data in [15:0] |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read word, combinational from the address |
| pad_in | input | 32 | Pin input levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin, 1 drives the pin |

## Verification
The bench sweeps single-bit masks over every bit of all four control registers. A design that tied the enable to the wrong bit would change a neighbouring pin, and a design that ignored the mask would clear pins it should keep. Disjoint-mask pairs catch any write that rewrites the whole half.

A full sweep of the 4 KB address space, with all-ones writes and reads, catches a decoder that aliases an unmapped address onto a control register or lets the status words accept writes. The synchroniser is probed one edge and two edges after an input change, which exposes a stage too few or too many.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_DOUT_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DOUT_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DIR_LO  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DIR_HI  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_PINS    = 12'h070;
  localparam logic [ADDR_W-1:0] OFS_VER     = 12'h078;

  localparam logic [31:0] VERSION_ID = 32'h0101_157C;

  // Enum order matches the half-register index used in the top module.
  typedef enum logic [2:0] {
    SEL_DOUT_LO = 3'd0,
    SEL_DOUT_HI = 3'd1,
    SEL_DIR_LO  = 3'd2,
    SEL_DIR_HI  = 3'd3,
    SEL_PINS    = 3'd4,
    SEL_VER     = 3'd5,
    SEL_NONE    = 3'd6
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DOUT_LO: return SEL_DOUT_LO;
      OFS_DOUT_HI: return SEL_DOUT_HI;
      OFS_DIR_LO:  return SEL_DIR_LO;
      OFS_DIR_HI:  return SEL_DIR_HI;
      OFS_PINS:    return SEL_PINS;
      OFS_VER:     return SEL_VER;
      default:     return SEL_NONE;
    endcase
  endfunction

  function automatic logic is_ctrl(input reg_sel_e s);
    return (s == SEL_DOUT_LO) || (s == SEL_DOUT_HI) ||
           (s == SEL_DIR_LO)  || (s == SEL_DIR_HI);
  endfunction

endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Bits under a set mask bit take new data; the rest keep their value.
  always_comb nxt = (q & ~wmask) | (wdata & wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  wr_en,
  input  logic [2*HALF_W-1:0]   wr_data,
  input  logic                  rd_en,
  output logic [2*HALF_W-1:0]   rd_data,
  input  logic [2*HALF_W-1:0]   pad_in,
  output logic [2*HALF_W-1:0]   pad_out,
  output logic [2*HALF_W-1:0]   pad_oe
);

  localparam int BUS_W    = 2 * HALF_W;
  localparam int N_PINS   = 2 * HALF_W;
  localparam int N_HALVES = 4;

  reg_sel_e sel;
  assign sel = decode_addr(bus_addr);

  // Named internal events, visible to the checker.
  logic [N_HALVES-1:0] half_we;
  logic                ctrl_hit;
  logic [HALF_W-1:0]   half_q [N_HALVES];
  logic [N_PINS-1:0]   pins_sync;

  assign ctrl_hit = is_ctrl(sel);

  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    assign half_we[g] = wr_en && (sel == reg_sel_e'(g));
    gpio_half_reg #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (half_we[g]),
      .wdata (wr_data[HALF_W-1:0]),
      .wmask (wr_data[BUS_W-1:HALF_W]),
      .q     (half_q[g])
    );
  end

  gpio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pins_sync)
  );

  assign pad_out = {half_q[1], half_q[0]};
  assign pad_oe  = {half_q[3], half_q[2]};

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (sel)
        SEL_DOUT_LO: rd_data = {{HALF_W{1'b0}}, half_q[0]};
        SEL_DOUT_HI: rd_data = {{HALF_W{1'b0}}, half_q[1]};
        SEL_DIR_LO:  rd_data = {{HALF_W{1'b0}}, half_q[2]};
        SEL_DIR_HI:  rd_data = {{HALF_W{1'b0}}, half_q[3]};
        SEL_PINS:    rd_data = pins_sync;
        SEL_VER:     rd_data = BUS_W'(VERSION_ID);
        default:     rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mask_ctrl_chk.sv
module gpio_mask_ctrl_chk
  import gpio_mask_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                wr_en,
  input logic [2*HALF_W-1:0] wr_data,
  input logic                rd_en,
  input logic [2*HALF_W-1:0] rd_data,
  input logic [2*HALF_W-1:0] pad_in,
  input logic [2*HALF_W-1:0] pad_out,
  input logic [2*HALF_W-1:0] pad_oe,
  input logic [3:0]          half_we,
  input logic                ctrl_hit
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  logic [HALF_W-1:0] msk;
  assign msk = wr_data[2*HALF_W-1:HALF_W];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_out == '0 && pad_oe == '0));

  // R2: unmasked bits of the low output half hold across a write.
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_DOUT_LO) |=>
      ((pad_out[HALF_W-1:0] & ~$past(msk)) == ($past(pad_out[HALF_W-1:0]) & ~$past(msk))));

  p_dir_hi_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_DIR_HI) |=>
      ((pad_oe[2*HALF_W-1:HALF_W] & $past(msk)) == ($past(wr_data[HALF_W-1:0]) & $past(msk))));

  p_one_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(half_we));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ctrl_hit) |-> (rd_data[2*HALF_W-1:HALF_W] == '0));

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_PINS && since_rst >= 2) |-> (rd_data == $past(pad_in, 2)));

  p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == OFS_VER) |-> (rd_data == VERSION_ID));

  p_ignore_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_hit) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind gpio_mask_ctrl gpio_mask_ctrl_chk #(.HALF_W(HALF_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .half_we  (half_we),
  .ctrl_hit (ctrl_hit)
);

// File: tb/gpio_mask_ctrl_tb_top.sv
module gpio_mask_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model: the four 16-bit halves, index = offset / 4.
  logic [15:0] mdl [4];

  always #4 clk = ~clk;

  gpio_mask_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Per-bit merge written bit by bit, independent of the RTL expression.
  function automatic logic [15:0] apply_word(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] r = old;
    for (int b = 0; b < 16; b++) if (w[b+16]) r[b] = w[b];
    return r;
  endfunction

  function automatic bit mapped_ctrl(input logic [11:0] a);
    return a == 12'h000 || a == 12'h004 || a == 12'h008 || a == 12'h00C;
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (mapped_ctrl(a)) mdl[a[3:2]] = apply_word(mdl[a[3:2]], d);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic check_pads(input string req);
    chk(req, pad_out, {mdl[1], mdl[0]});
    chk(req, pad_oe,  {mdl[3], mdl[2]});
  endtask

  task automatic check_readback(input string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      bus_read(12'(i * 4), v);
      chk(req, v, {16'h0000, mdl[i]});
    end
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] v;
    seed = 32'h1234_5678;
    for (int i = 0; i < 4; i++) mdl[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset pad_out", pad_out, 32'h0);
    chk("R1 reset pad_oe", pad_oe, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_pads("R1 after release");
    check_readback("R1 readback");

    // R10: idle read bus is zero
    bus_addr = 12'h078; rd_en = 1'b0; #1;
    chk("R10 idle rd_data", rd_data, 32'h0);

    // R2/R3/R4: single-bit masks over every bit of every control register
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 16; b++) begin
        bus_write(12'(r * 4), (32'h1 << (b + 16)) | 32'h0000_FFFF);
        check_pads("R2 single-bit set");
      end
      for (int b = 0; b < 16; b += 2) begin
        bus_write(12'(r * 4), 32'h1 << (b + 16));
        check_pads("R2 single-bit clear");
      end
    end
    check_readback("R5 readback after sweep");

    // R2: mask of zero changes nothing even with all data ones
    for (int r = 0; r < 4; r++) begin
      bus_write(12'(r * 4), 32'h0000_FFFF);
      check_pads("R2 empty mask");
    end

    // R3/R4/R5: pseudo-random masked writes
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      logic [1:0]  r;
      seed = seed * 32'd1664525 + 32'd1013904223;
      d = seed;
      r = seed[9:8] ^ seed[29:28];
      bus_write({8'h00, r, 2'b00}, d);
      check_pads(r[1] ? "R4 direction write" : "R3 output write");
      bus_read({8'h00, r, 2'b00}, v);
      chk("R5 readback", v, {16'h0000, mdl[r]});
    end

    // R9: disjoint-mask writer pairs
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] m;
        logic [15:0] da;
        logic [15:0] db;
        seed = seed * 32'd1664525 + 32'd1013904223;
        m  = seed[15:0];
        da = seed[31:16];
        db = ~seed[31:16];
        bus_write(12'(r * 4), {m, da});
        bus_write(12'(r * 4), {~m, db});
        chk("R9 disjoint pair", {pad_oe, pad_out} >> (r[1] ? 32 : 0) >> (r[0] ? 16 : 0) & 64'hFFFF,
            {48'h0, (da & m) | (db & ~m)});
        check_pads("R9 pads");
      end
    end

    // R7: version word
    bus_read(12'h078, v);
    chk("R7 version", v, 32'h0101_157C);

    // R8: full address sweep, writes of all ones ignored outside control regs
    bus_write(12'h000, 32'hFFFF_A5C3);
    bus_write(12'h00C, 32'hFFFF_3C5A);
    for (int a = 0; a < 4096; a += 4) begin
      if (!mapped_ctrl(12'(a))) begin
        bus_write(12'(a), 32'hFFFF_FFFF);
        if (a == 12'h070 || a == 12'h078 || a[3:0] == 0) check_pads("R8 ignored write");
        bus_read(12'(a), v);
        if (a == 12'h078)      chk("R8 version after write", v, 32'h0101_157C);
        else if (a == 12'h070) chk("R8 pins after write", v, 32'h0);
        else                   chk("R8 unmapped read", v, 32'h0);
      end
    end
    check_pads("R8 after sweep");
    check_readback("R8 readback after sweep");

    // R6: synchroniser latency, pattern changes at a negedge
    for (int i = 0; i < 6; i++) begin
      logic [31:0] old_v;
      logic [31:0] new_v;
      old_v = pad_in;
      seed = seed * 32'd1664525 + 32'd1013904223;
      new_v = (i == 0) ? 32'hFFFF_FFFF : seed;
      @(negedge clk);
      pad_in = new_v;
      bus_addr = 12'h070; rd_en = 1'b1; #1;
      chk("R6 before any edge", rd_data, old_v);
      @(negedge clk); #1;
      chk("R6 after one edge", rd_data, old_v);
      @(negedge clk); #1;
      chk("R6 after two edges", rd_data, new_v);
      rd_en = 1'b0;
    end

    // R1: reset mid-run clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    @(negedge clk);
    chk("R1 reset mid-run out", pad_out, 32'h0);
    chk("R1 reset mid-run oe", pad_oe, 32'h0);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule